// File: doc/BRIEF.md
# Serial Slave Port with Clock Polarity Detection

This block is the serial front end of a register-mapped peripheral. An external master selects it with a chip-enable line and then clocks address and data bytes over a serial clock. The port needs no configuration of the clock mode. Each time chip enable goes active, it records the resting level of the serial clock. From that level it knows which clock edge leaves the rest level and which edge returns to it.

The first byte of every frame is a command that carries a direction bit and a 7-bit register address. The bytes that follow are data. Each byte is either written into, or fetched from, a simple byte-wide register bank through a one-cycle handshake. The address steps forward after every data byte, so a whole burst fits in one frame.

A static mode input picks one of two pin layouts. One has separate input and output lines. The other is a 3-wire layout in which one shared line turns around for read data. The output enable drives the pad's tri-state buffer. All serial pins are resynchronised into the system clock domain, so the system clock must run well above the serial clock.

Top module: `spi_autopol_slave`

## Requirements
- R1: The serial clock level seen when chip enable goes active is held as the rest level for the whole frame, and transfers work identically for a rest level of 0 and of 1.
- R2: An input bit is captured on the clock edge that returns the clock to its rest level. The output line changes only on the edge that leaves the rest level.
- R3: Bytes are 8 bits, most significant bit first. The first byte of a frame is a command: bit 7 = 1 means write and bit 7 = 0 means read, and bits 6..0 are the start address.
- R4: Each complete data byte of a write frame produces exactly one single-cycle `reg_wr` pulse, with that byte on `reg_wdata` and its address on `reg_addr`.
- R5: `dout_oe` is 0 after reset, while the command byte is shifted, and throughout write frames. In a read frame it goes to 1 on the first leaving edge of the first data byte. Read data is requested with a single-cycle `reg_rd` pulse, and `reg_rdata` is taken one system clock later.
- R6: The address rises by one after every data byte within a frame and wraps from 127 to 0.
- R7: When chip enable drops in the middle of a byte, the partial byte is discarded and causes no register write. `dout_oe` returns to 0, and the next frame starts with a command byte.
- R8: With `spi_mode` = 1, serial input is taken from `sdi` and `sio_i` is ignored. With `spi_mode` = 0, serial input is taken from `sio_i` and `sdi` is ignored.
- R9: Input bits received during the data bytes of a read frame cause no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Chip enable from the master, active high, asynchronous |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| sdi | input | 1 | Serial data in, used in separate-line mode |
| sio_i | input | 1 | Input buffer of the shared line, used in 3-wire mode |
| spi_mode | input | 1 | 1 = separate in/out lines, 0 = 3-wire shared line (static) |
| dout | output | 1 | Serial data out (the shared line's output in 3-wire mode) |
| dout_oe | output | 1 | Tri-state enable for `dout` |
| reg_addr | output | 7 | Register bank address |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | Single-cycle read request |
| reg_rdata | input | 8 | Read data, valid one cycle after `reg_rd` |

## Verification
A single frame writes all 128 registers with an arithmetic pattern. It then writes one further byte, which tests the wrap to address 0. The full bank is then read back under each of the four combinations of rest level and pin layout. A bit-order, edge-choice or polarity error shows up as a corrupted pattern. The unused input line is always driven with the inverse of the real data, which exposes a wrong line selection at once.

Short bursts starting at address 127 exercise the wrap in every configuration. During read data bytes, and during the command byte of a read, the bench samples the output enable and drives junk input. Frames aborted inside a command byte, a write data byte and a read data byte then show whether a partial byte leaks into the bank or leaves the output enabled.

// File: rtl/spi_ap_pkg.sv
// Shared types for the serial slave port.
// Assumes: nothing beyond SystemVerilog 2017.
package spi_ap_pkg;

    // Frame phase: command byte, write data, read data.
    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_t;

endpackage

// File: rtl/spi_ap_sync.sv
// Two-stage synchroniser for a vector of independent asynchronous bits.
// Assumes: each bit is a level that may be sampled late by two clocks.
module spi_ap_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Two flip-flops per bit against metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[i] <= 1'b0;
                stage2[i] <= 1'b0;
            end else begin
                stage1[i] <= d_async[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign d_sync = stage2;

endmodule

// File: rtl/spi_ap_edge.sv
// Frame and clock edge detector. It finds chip-enable start and stop,
// holds the serial clock rest level taken at frame start, and classifies
// serial clock transitions as leaving (shift) or returning (strobe) edges.
// Assumes: inputs are already synchronised to clk.
module spi_ap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_s,
    input  logic sclk_s,
    output logic frame_start,
    output logic frame_stop,
    output logic lead_edge,
    output logic trail_edge,
    output logic rest_pol
);

    logic ce_q;
    logic sclk_q;
    logic active;
    logic changed;

    // Delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            ce_q   <= ce_s;
            sclk_q <= sclk_s;
        end
    end

    // Capture the clock rest level when a frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rest_pol <= 1'b0;
        end else if (frame_start) begin
            rest_pol <= sclk_s;
        end
    end

    // Classify edges only inside an established frame.
    always_comb begin
        frame_start = ce_s & ~ce_q;
        frame_stop  = ~ce_s & ce_q;
        active      = ce_s & ce_q;
        changed     = sclk_s ^ sclk_q;
        lead_edge   = active & changed & (sclk_s != rest_pol);
        trail_edge  = active & changed & (sclk_s == rest_pol);
    end

endmodule

// File: rtl/spi_ap_ctrl.sv
// Byte assembler and frame sequencer. It shifts in bits on strobe edges,
// decodes the command byte, issues register write and read strobes, and
// steps the address after every data byte.
// Assumes: strobe edges are at least a few clk cycles apart.
module spi_ap_ctrl
    import spi_ap_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = DATA_W - 1,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stop,
    input  logic              trail_edge,
    input  logic              bit_in,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    output logic              in_read
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    phase_t            phase;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] rx_next;
    logic [CNT_W-1:0]  bit_cnt;
    logic              byte_done;

    // Next shift value and byte completion on a strobe edge.
    always_comb begin
        rx_next   = {rx_sh[DATA_W-2:0], bit_in};
        byte_done = trail_edge && (bit_cnt == LAST_BIT);
        in_read   = (phase == PH_READ);
    end

    // Bit counter and shift register; frame stop drops the partial byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            bit_cnt <= '0;
        end else if (frame_stop) begin
            rx_sh   <= '0;
            bit_cnt <= '0;
        end else if (trail_edge) begin
            rx_sh   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Phase sequencing, address stepping and register strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_CMD;
            reg_addr  <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (reg_wr) begin
                reg_addr <= reg_addr + 1'b1;
            end
            if (frame_stop) begin
                phase <= PH_CMD;
            end else if (byte_done) begin
                unique case (phase)
                    PH_CMD: begin
                        reg_addr <= rx_next[ADDR_W-1:0];
                        if (rx_next[DATA_W-1]) begin
                            phase <= PH_WRITE;
                        end else begin
                            phase  <= PH_READ;
                            reg_rd <= 1'b1;
                        end
                    end
                    PH_WRITE: begin
                        reg_wr    <= 1'b1;
                        reg_wdata <= rx_next;
                    end
                    PH_READ: begin
                        reg_addr <= reg_addr + 1'b1;
                        reg_rd   <= 1'b1;
                    end
                    default: phase <= PH_CMD;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_ap_tx.sv
// Output shifter. It loads a fetched byte, presents the next bit on each
// leaving edge during read data, and owns the tri-state enable.
// Assumes: the load arrives before the first leaving edge of its byte.
module spi_ap_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stop,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              lead_edge,
    input  logic              in_read,
    output logic              dout,
    output logic              dout_oe
);

    logic [DATA_W-1:0] tx_sh;

    // Shift register load and shift on leaving edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (load) begin
            tx_sh <= load_data;
        end else if (lead_edge && in_read) begin
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
    end

    // Output bit and enable; released when the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (frame_stop) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (lead_edge && in_read) begin
            dout    <= tx_sh[DATA_W-1];
            dout_oe <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_autopol_slave.sv
// Serial slave port with clock rest-level detection, a command/data byte
// protocol and a register bank handshake. The separate-line or 3-wire pin
// layout is chosen by spi_mode.
// Assumes: clk is several times faster than sclk; spi_mode is static.
module spi_autopol_slave #(
    parameter int DATA_W = 8,
    localparam int ADDR_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              sio_i,
    input  logic              spi_mode,
    output logic              dout,
    output logic              dout_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);

    logic       din_raw;
    logic [2:0] sync_out;
    logic       ce_s;
    logic       sclk_s;
    logic       din_s;
    logic       frame_start;
    logic       frame_stop;
    logic       lead_edge;
    logic       trail_edge;
    logic       rest_pol;
    logic       in_read;
    logic       rd_q;

    // Pick the input line for the selected pin layout.
    always_comb begin
        din_raw = spi_mode ? sdi : sio_i;
        ce_s    = sync_out[2];
        sclk_s  = sync_out[1];
        din_s   = sync_out[0];
    end

    spi_ap_sync #(.W(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ce, sclk, din_raw}),
        .d_sync  (sync_out)
    );

    spi_ap_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_s        (ce_s),
        .sclk_s      (sclk_s),
        .frame_start (frame_start),
        .frame_stop  (frame_stop),
        .lead_edge   (lead_edge),
        .trail_edge  (trail_edge),
        .rest_pol    (rest_pol)
    );

    spi_ap_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stop (frame_stop),
        .trail_edge (trail_edge),
        .bit_in     (din_s),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rd     (reg_rd),
        .in_read    (in_read)
    );

    // Read data is valid one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else begin
            rd_q <= reg_rd;
        end
    end

    spi_ap_tx #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stop (frame_stop),
        .load       (rd_q),
        .load_data  (reg_rdata),
        .lead_edge  (lead_edge),
        .in_read    (in_read),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );

endmodule

// File: rtl/spi_autopol_slave_chk.sv
// Assertion checker for spi_autopol_slave, attached by bind.
// Assumes: connected to the top module's internal synchronised signals.
module spi_autopol_slave_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_s,
    input logic              rest_pol,
    input logic              in_read,
    input logic              dout_oe,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr
);

    // R1: the rest level holds once a frame is established.
    a_r1_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_s && $past(ce_s) && $past(ce_s, 2)) |-> $stable(rest_pol));

    // R4: write strobe lasts one cycle.
    a_r4_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R5: read request lasts one cycle and never meets a write.
    a_r5_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    a_r5_wr_rd_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    // R5: the output is enabled only in the read data phase.
    a_r5_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> in_read);

    // R6: the address steps by one after every written byte.
    a_r6_wr_incr: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

    // R7: leaving the frame releases the output.
    a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_s) |=> !dout_oe);

    // R9: no write during the read data phase.
    a_r9_no_wr_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        in_read |-> !reg_wr);

endmodule

bind spi_autopol_slave spi_autopol_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_s     (ce_s),
    .rest_pol (rest_pol),
    .in_read  (in_read),
    .dout_oe  (dout_oe),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr)
);

// File: tb/tb_spi_autopol_slave.sv
// Bench for spi_autopol_slave: full-bank sweeps in all four configurations,
// wrap bursts and aborted frames, checked against a bench-side model.
module tb_spi_autopol_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       sio_i = 1'b0;
    logic       spi_mode = 1'b1;
    logic       dout;
    logic       dout_oe;
    logic [6:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic       reg_rd;
    logic [7:0] reg_rdata;

    logic [7:0] bank [128];
    logic [7:0] expv [128];
    int         wr_cnt;
    int         n_chk = 0;
    int         n_fail = 0;
    logic       pol = 1'b0;
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_autopol_slave dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi),
        .sio_i(sio_i), .spi_mode(spi_mode), .dout(dout), .dout_oe(dout_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    // Register bank model with a one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) bank[i] <= 8'h00;
            reg_rdata <= 8'h00;
            wr_cnt    <= 0;
        end else begin
            if (reg_wr) begin
                bank[reg_addr] <= reg_wdata;
                wr_cnt         <= wr_cnt + 1;
            end
            if (reg_rd) reg_rdata <= bank[reg_addr];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin(input logic p, input logic m);
        pol      = p;
        spi_mode = m;
        sclk     = p;
        wait_n(6);
        ce = 1'b1;
        wait_n(6);
    endtask

    task automatic frame_end();
        wait_n(6);
        ce = 1'b0;
        wait_n(6);
    endtask

    // Shift n bits of tx out MSB first; collect dout and the enable seen.
    task automatic xbits(input int n, input logic [7:0] tx,
                         output logic [7:0] rx, output int oe_ones);
        rx      = 8'h00;
        oe_ones = 0;
        for (int i = 7; i > 7 - n; i--) begin
            sclk = ~pol;
            if (spi_mode) begin sdi = tx[i]; sio_i = ~tx[i]; end
            else          begin sio_i = tx[i]; sdi = ~tx[i]; end
            wait_n(HALF);
            rx[i] = dout;
            if (dout_oe) oe_ones++;
            sclk = pol;
            wait_n(HALF);
        end
    endtask

    // Write a burst starting at addr and update the model.
    task automatic burst_write(input logic p, input logic m, input int addr,
                               input int len, input int seed);
        logic [7:0] rx;
        int oe1;
        frame_begin(p, m);
        xbits(8, 8'h80 | 8'(addr), rx, oe1);
        for (int k = 0; k < len; k++) begin
            xbits(8, 8'((seed + 37 * k) & 8'hFF), rx, oe1);
            expv[(addr + k) % 128] = 8'((seed + 37 * k) & 8'hFF);
        end
        frame_end();
    endtask

    // Read a burst and compare against the model.
    task automatic burst_read(input logic p, input logic m, input int addr,
                              input int len, input string req);
        logic [7:0] rx;
        int oe1;
        int wr_before;
        wr_before = wr_cnt;
        frame_begin(p, m);
        xbits(8, 8'(addr & 8'h7F), rx, oe1);
        chk(oe1 == 0, "R5 enable low during command byte", oe1, 0);
        for (int k = 0; k < len; k++) begin
            xbits(8, 8'hFF, rx, oe1);
            chk(rx == expv[(addr + k) % 128], req, rx, expv[(addr + k) % 128]);
            chk(oe1 == 8, "R5 enable high during read data", oe1, 8);
        end
        frame_end();
        chk(dout_oe == 1'b0, "R7 enable released after frame", dout_oe, 0);
        chk(wr_cnt == wr_before, "R9 read frame wrote nothing", wr_cnt, wr_before);
    endtask

    // Watchdog: a hung run still reaches the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        int oe1;
        int wb;
        for (int i = 0; i < 128; i++) expv[i] = 8'h00;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        chk(dout_oe == 1'b0, "R5 reset enable", dout_oe, 0);
        chk(reg_wr == 1'b0, "R4 reset write strobe", reg_wr, 0);
        chk(reg_rd == 1'b0, "R5 reset read strobe", reg_rd, 0);

        // R3 R4 R6: one frame writes 129 bytes, the last wraps to address 0.
        burst_write(1'b0, 1'b1, 0, 129, 5);
        chk(wr_cnt == 129, "R4 one strobe per data byte", wr_cnt, 129);

        // R1 R2 R8: full readback under each rest level and pin layout.
        burst_read(1'b0, 1'b1, 0, 128, "R1 R2 R8 rest0 separate-line readback");
        burst_read(1'b1, 1'b1, 0, 128, "R1 R2 R8 rest1 separate-line readback");
        burst_read(1'b0, 1'b0, 0, 128, "R1 R2 R8 rest0 3-wire readback");
        burst_read(1'b1, 1'b0, 0, 128, "R1 R2 R8 rest1 3-wire readback");

        // R6: wrap bursts written and read in every configuration.
        for (int c = 0; c < 4; c++) begin
            burst_write(logic'(c[0]), logic'(c[1]), 127, 3, 17 + 40 * c);
            burst_read(logic'(c[0]), logic'(c[1]), 127, 3, "R6 wrap 127 to 0");
        end

        // R7: abort inside a write data byte.
        wb = wr_cnt;
        frame_begin(1'b1, 1'b1);
        xbits(8, 8'h90, rx, oe1);
        xbits(8, 8'hC3, rx, oe1);
        expv[16] = 8'hC3;
        xbits(4, 8'hA5, rx, oe1);
        frame_end();
        chk(wr_cnt == wb + 1, "R7 partial write byte discarded", wr_cnt, wb + 1);

        // R7: abort inside a command byte, then a fresh frame decodes a command.
        frame_begin(1'b0, 1'b0);
        xbits(3, 8'hE0, rx, oe1);
        frame_end();
        burst_read(1'b0, 1'b0, 16, 2, "R7 fresh command after aborts");

        // R7: abort inside a read data byte releases the output.
        frame_begin(1'b1, 1'b0);
        xbits(8, 8'h10, rx, oe1);
        xbits(5, 8'h00, rx, oe1);
        chk(dout_oe == 1'b1, "R5 enable high mid read byte", dout_oe, 1);
        frame_end();
        chk(dout_oe == 1'b0, "R7 enable released after read abort", dout_oe, 0);
        burst_read(1'b1, 1'b1, 16, 1, "R7 data intact after read abort");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule